// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between the clock sources of a system clock generator and its output pins. It takes four already generated source clocks (processor, PCI, memory and interrupt-controller reference) and forwards each one to a group of outputs. Each output clock can be parked low without ever emitting a shortened high pulse. Two active-low stop inputs control the parking. The global stop acts on the processor, memory and interrupt-controller outputs. The PCI stop acts only on the PCI outputs. A per-output enable vector, normally driven from configuration registers, holds individual outputs low.

Every domain also has one free-running output. The stop inputs never touch it, and only its own enable bit controls it. A two-bit mode input can request high impedance for all clock pins. In that case the block drives a single output-enable low for the pad ring. Frequency synthesis and division are outside this block.

Each stop or enable request crosses into its clock domain through a synchronizer clocked on the rising edge. The gate itself is then updated on the falling edge, while the source clock is low. Every output pulse is therefore either a whole source pulse or absent.

Top module: `clock_stop_ctrl`

## Requirements
- R1: While `rst_ni` is low, every clock output is 0. After release, every output whose enable bit is 1 toggles again, and the stop inputs do not hold it.
- R2: When `stop_all_ni` falls during the low phase of `cpu_clk_i`, the stopped processor outputs pass exactly two more rising edges and then stay 0. The memory and interrupt-controller outputs stop within three cycles of their own source.
- R3: When `stop_all_ni` rises during the low phase of `cpu_clk_i`, the processor outputs stay 0 for the next two rising edges. They carry a full high pulse from the third rising edge on.
- R4: `cpu_free_o`, `pci_free_o`, `mem_free_o` and `irq_free_o` keep toggling while either stop input, or both, is low.
- R5: `pci_stop_ni` is sampled on the rising edge of `pci_clk_i`. The pulse at the sampling edge is passed, and the level takes effect from the next rising edge. This applies both to parking and to resuming.
- R6: `pci_stop_ni` has no effect on the processor, memory or interrupt-controller outputs. `stop_all_ni` has no effect on the PCI outputs.
- R7: An enable bit of 0 drives its output(s) to 0, and all other outputs keep running. Bit i of `cpu_en_i` and of `pci_en_i` controls output i of the same domain. Bit g of `mem_en_i` controls `mem_gated_o[4g+3:4g]`.
- R8: Every high pulse on every clock output lasts exactly half a period of its source clock. This holds across stops, restarts, enable changes and reset release.
- R9: `out_en_o` is 0 when `mode_i` is 2'b11 and 1 for the codes 2'b00, 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Processor source clock |
| pci_clk_i | input | 1 | PCI source clock |
| mem_clk_i | input | 1 | Memory source clock |
| ref_clk_i | input | 1 | Interrupt-controller reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_all_ni | input | 1 | Active-low global stop |
| pci_stop_ni | input | 1 | Active-low PCI stop |
| mode_i | input | 2 | Output mode; 2'b11 requests high impedance |
| cpu_en_i | input | N_CPU | Enables for the stoppable processor outputs |
| cpu_free_en_i | input | 1 | Enable for the free-running processor output |
| pci_en_i | input | N_PCI | Enables for the stoppable PCI outputs |
| pci_free_en_i | input | 1 | Enable for the free-running PCI output |
| mem_en_i | input | N_MEM_GRP | Group enables for the stoppable memory outputs |
| mem_free_en_i | input | 1 | Enable for the free-running memory output |
| irq_en_i | input | 1 | Enable for the stoppable interrupt-controller output |
| irq_free_en_i | input | 1 | Enable for the free-running interrupt-controller output |
| cpu_gated_o | output | N_CPU | Stoppable processor clocks |
| cpu_free_o | output | 1 | Free-running processor clock |
| pci_gated_o | output | N_PCI | Stoppable PCI clocks |
| pci_free_o | output | 1 | Free-running PCI clock |
| mem_gated_o | output | N_MEM_GRP*MEM_PER_GRP | Stoppable memory clocks |
| mem_free_o | output | 1 | Free-running memory clock |
| irq_gated_o | output | 1 | Stoppable interrupt-controller clock |
| irq_free_o | output | 1 | Free-running interrupt-controller clock |
| out_en_o | output | 1 | Pad output enable; 0 means all clock pins float |

## Verification
A wrong gate flop shows at once as a clipped or an extra high pulse on the affected pin. That pulse is seen on the same source cycle in which the gate changes. A synchronizer with a missing or extra stage moves the park or resume point by one whole source cycle. That shift is visible within three cycles of the stop edge as a wrong level on the first, second or third rising edge. A cross-wired stop or enable shows within a few hundred nanoseconds as an output that goes quiet, or keeps running, against its own domain's rule.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_BYPASS = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_FLOAT  = 2'b11
  } csc_mode_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/csc_rst_sync.sv
`timescale 1ns/1ps
module csc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d    = chain_q << 1;
    chain_d[0] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/csc_gate_cell.sv
`timescale 1ns/1ps
module csc_gate_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   gate_q;
  logic                   gate_d;

  // rising-edge sampling chain for the asynchronous run request
  always_comb begin
    sync_d    = sync_q << 1;
    sync_d[0] = run_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  // gate moves only while the source is low, so high pulses stay whole
  always_comb gate_d = sync_q[SYNC_STAGES-1];

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_d;
  end

  assign clk_o = clk_i & gate_q;

endmodule

// File: rtl/csc_domain.sv
`timescale 1ns/1ps
module csc_domain #(
  parameter int unsigned N_GATED     = 2,
  parameter int unsigned FANOUT      = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        stop_ni,
  input  logic [N_GATED-1:0]          en_i,
  input  logic                        free_en_i,
  output logic [N_GATED*FANOUT-1:0]   gated_o,
  output logic                        free_o
);

  localparam int unsigned N_OUT = N_GATED * FANOUT;

  logic               rst_dom_n;
  logic [N_GATED-1:0] run;
  logic [N_GATED-1:0] cell_clk;

  csc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_dom_n)
  );

  always_comb run = en_i & {N_GATED{stop_ni}};

  for (genvar g = 0; g < N_GATED; g++) begin : g_gate
    csc_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_dom_n),
      .run_i  (run[g]),
      .clk_o  (cell_clk[g])
    );
    for (genvar k = 0; k < FANOUT; k++) begin : g_fan
      assign gated_o[g*FANOUT+k] = cell_clk[g];
    end
  end

  csc_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_free (
    .clk_i  (clk_i),
    .rst_ni (rst_dom_n),
    .run_i  (free_en_i),
    .clk_o  (free_o)
  );

  if (N_OUT == 0) begin : g_bad_cfg
    initial $display("csc_domain: empty output group");
  end

endmodule

// File: rtl/clock_stop_ctrl.sv
`timescale 1ns/1ps
module clock_stop_ctrl
  import csc_pkg::*;
#(
  parameter int unsigned N_CPU       = 2,
  parameter int unsigned N_PCI       = 6,
  parameter int unsigned N_MEM_GRP   = 4,
  parameter int unsigned MEM_PER_GRP = 4,
  parameter int unsigned CPU_SYNC    = 2,
  parameter int unsigned PCI_SYNC    = 1
) (
  input  logic                            cpu_clk_i,
  input  logic                            pci_clk_i,
  input  logic                            mem_clk_i,
  input  logic                            ref_clk_i,
  input  logic                            rst_ni,
  input  logic                            stop_all_ni,
  input  logic                            pci_stop_ni,
  input  logic [1:0]                      mode_i,
  input  logic [N_CPU-1:0]                cpu_en_i,
  input  logic                            cpu_free_en_i,
  input  logic [N_PCI-1:0]                pci_en_i,
  input  logic                            pci_free_en_i,
  input  logic [N_MEM_GRP-1:0]            mem_en_i,
  input  logic                            mem_free_en_i,
  input  logic                            irq_en_i,
  input  logic                            irq_free_en_i,
  output logic [N_CPU-1:0]                cpu_gated_o,
  output logic                            cpu_free_o,
  output logic [N_PCI-1:0]                pci_gated_o,
  output logic                            pci_free_o,
  output logic [N_MEM_GRP*MEM_PER_GRP-1:0] mem_gated_o,
  output logic                            mem_free_o,
  output logic                            irq_gated_o,
  output logic                            irq_free_o,
  output logic                            out_en_o
);

  csc_domain #(
    .N_GATED(N_CPU), .FANOUT(1), .SYNC_STAGES(CPU_SYNC), .RST_STAGES(RST_SYNC_STAGES)
  ) u_cpu (
    .clk_i     (cpu_clk_i),
    .rst_ni    (rst_ni),
    .stop_ni   (stop_all_ni),
    .en_i      (cpu_en_i),
    .free_en_i (cpu_free_en_i),
    .gated_o   (cpu_gated_o),
    .free_o    (cpu_free_o)
  );

  csc_domain #(
    .N_GATED(N_PCI), .FANOUT(1), .SYNC_STAGES(PCI_SYNC), .RST_STAGES(RST_SYNC_STAGES)
  ) u_pci (
    .clk_i     (pci_clk_i),
    .rst_ni    (rst_ni),
    .stop_ni   (pci_stop_ni),
    .en_i      (pci_en_i),
    .free_en_i (pci_free_en_i),
    .gated_o   (pci_gated_o),
    .free_o    (pci_free_o)
  );

  csc_domain #(
    .N_GATED(N_MEM_GRP), .FANOUT(MEM_PER_GRP), .SYNC_STAGES(CPU_SYNC), .RST_STAGES(RST_SYNC_STAGES)
  ) u_mem (
    .clk_i     (mem_clk_i),
    .rst_ni    (rst_ni),
    .stop_ni   (stop_all_ni),
    .en_i      (mem_en_i),
    .free_en_i (mem_free_en_i),
    .gated_o   (mem_gated_o),
    .free_o    (mem_free_o)
  );

  csc_domain #(
    .N_GATED(1), .FANOUT(1), .SYNC_STAGES(CPU_SYNC), .RST_STAGES(RST_SYNC_STAGES)
  ) u_irq (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .stop_ni   (stop_all_ni),
    .en_i      (irq_en_i),
    .free_en_i (irq_free_en_i),
    .gated_o   (irq_gated_o),
    .free_o    (irq_free_o)
  );

  always_comb out_en_o = (csc_mode_e'(mode_i) != MODE_FLOAT);

endmodule

// File: rtl/csc_checker.sv
`timescale 1ns/1ps
module csc_checker #(
  parameter int unsigned N_CPU      = 2,
  parameter int unsigned N_PCI      = 6,
  parameter int unsigned CPU_SYNC   = 2,
  parameter int unsigned PCI_SYNC   = 1,
  parameter int unsigned RST_STAGES = 2
) (
  input logic             cpu_clk_i,
  input logic             pci_clk_i,
  input logic             rst_ni,
  input logic             stop_all_ni,
  input logic             pci_stop_ni,
  input logic [N_CPU-1:0] cpu_en_i,
  input logic             cpu_free_en_i,
  input logic [N_PCI-1:0] pci_en_i,
  input logic             pci_free_en_i,
  input logic [N_CPU-1:0] cpu_gated_o,
  input logic             cpu_free_o,
  input logic [N_PCI-1:0] pci_gated_o,
  input logic             pci_free_o
);

  localparam int unsigned CW         = 5;
  localparam int unsigned CPU_PARK_N = CPU_SYNC + 1;
  localparam int unsigned CPU_RUN_N  = RST_STAGES + CPU_SYNC + 1;
  localparam int unsigned PCI_PARK_N = PCI_SYNC + 1;
  localparam int unsigned PCI_RUN_N  = RST_STAGES + PCI_SYNC + 1;

  logic [CW-1:0] cpu_park_cnt, cpu_run_cnt, cpu_free_cnt;
  logic [CW-1:0] pci_park_cnt, pci_run_cnt, pci_free_cnt;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c, input logic cond);
    if (!cond) return '0;
    return (c == '1) ? c : c + 1'b1;
  endfunction

  // consecutive falling edges for which each condition has held
  always_ff @(negedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_park_cnt <= '0;
      cpu_run_cnt  <= '0;
      cpu_free_cnt <= '0;
    end else begin
      cpu_park_cnt <= bump(cpu_park_cnt, !stop_all_ni);
      cpu_run_cnt  <= bump(cpu_run_cnt, stop_all_ni && cpu_en_i[0]);
      cpu_free_cnt <= bump(cpu_free_cnt, cpu_free_en_i);
    end
  end

  always_ff @(negedge pci_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pci_park_cnt <= '0;
      pci_run_cnt  <= '0;
      pci_free_cnt <= '0;
    end else begin
      pci_park_cnt <= bump(pci_park_cnt, !pci_stop_ni);
      pci_run_cnt  <= bump(pci_run_cnt, pci_stop_ni && pci_en_i[0]);
      pci_free_cnt <= bump(pci_free_cnt, pci_free_en_i);
    end
  end

  AST_CPU_PARKED: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (cpu_park_cnt >= CW'(CPU_PARK_N)) |-> (cpu_gated_o == '0)); // R2

  AST_CPU_RESUMED: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (cpu_run_cnt >= CW'(CPU_RUN_N)) |-> cpu_gated_o[0]); // R3

  AST_CPU_FREE_RUNS: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (cpu_free_cnt >= CW'(CPU_RUN_N)) |-> cpu_free_o); // R4

  AST_PCI_PARKED: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    (pci_park_cnt >= CW'(PCI_PARK_N)) |-> (pci_gated_o == '0)); // R5

  AST_PCI_RESUMED: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    (pci_run_cnt >= CW'(PCI_RUN_N)) |-> pci_gated_o[0]); // R5

  AST_PCI_FREE_RUNS: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    (pci_free_cnt >= CW'(PCI_RUN_N)) |-> pci_free_o); // R4

  AST_CPU_NO_HIGH_SRC_LOW: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    (cpu_gated_o == '0) && !cpu_free_o); // R8

  AST_PCI_NO_HIGH_SRC_LOW: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (pci_gated_o == '0) && !pci_free_o); // R8

endmodule

bind clock_stop_ctrl csc_checker #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .CPU_SYNC(CPU_SYNC), .PCI_SYNC(PCI_SYNC),
  .RST_STAGES(csc_pkg::RST_SYNC_STAGES)
) u_csc_checker (
  .cpu_clk_i     (cpu_clk_i),
  .pci_clk_i     (pci_clk_i),
  .rst_ni        (rst_ni),
  .stop_all_ni   (stop_all_ni),
  .pci_stop_ni   (pci_stop_ni),
  .cpu_en_i      (cpu_en_i),
  .cpu_free_en_i (cpu_free_en_i),
  .pci_en_i      (pci_en_i),
  .pci_free_en_i (pci_free_en_i),
  .cpu_gated_o   (cpu_gated_o),
  .cpu_free_o    (cpu_free_o),
  .pci_gated_o   (pci_gated_o),
  .pci_free_o    (pci_free_o)
);

// File: tb/tb_clock_stop_ctrl.sv
`timescale 1ns/1ps
module tb_clock_stop_ctrl;

  localparam int N_OBS = 29;
  localparam int N_EN  = 17;

  logic cpu_clk, pci_clk, mem_clk, ref_clk;
  logic rst_n, stop_all_n, pci_stop_n;
  logic [1:0] mode;
  logic [N_EN-1:0] en_all;

  logic [1:0]  cpu_gated;
  logic        cpu_free;
  logic [5:0]  pci_gated;
  logic        pci_free;
  logic [15:0] mem_gated;
  logic        mem_free;
  logic        irq_gated;
  logic        irq_free;
  logic        out_en;
  logic [N_OBS-1:0] obs;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial begin cpu_clk = 0; forever #4 cpu_clk = ~cpu_clk; end
  initial begin pci_clk = 0; forever #12 pci_clk = ~pci_clk; end
  initial begin mem_clk = 0; forever #5 mem_clk = ~mem_clk; end
  initial begin ref_clk = 0; forever #7 ref_clk = ~ref_clk; end

  clock_stop_ctrl dut (
    .cpu_clk_i     (cpu_clk),
    .pci_clk_i     (pci_clk),
    .mem_clk_i     (mem_clk),
    .ref_clk_i     (ref_clk),
    .rst_ni        (rst_n),
    .stop_all_ni   (stop_all_n),
    .pci_stop_ni   (pci_stop_n),
    .mode_i        (mode),
    .cpu_en_i      (en_all[1:0]),
    .cpu_free_en_i (en_all[2]),
    .pci_en_i      (en_all[8:3]),
    .pci_free_en_i (en_all[9]),
    .mem_en_i      (en_all[13:10]),
    .mem_free_en_i (en_all[14]),
    .irq_en_i      (en_all[15]),
    .irq_free_en_i (en_all[16]),
    .cpu_gated_o   (cpu_gated),
    .cpu_free_o    (cpu_free),
    .pci_gated_o   (pci_gated),
    .pci_free_o    (pci_free),
    .mem_gated_o   (mem_gated),
    .mem_free_o    (mem_free),
    .irq_gated_o   (irq_gated),
    .irq_free_o    (irq_free),
    .out_en_o      (out_en)
  );

  assign obs = {irq_free, irq_gated, mem_free, mem_gated, pci_free, pci_gated, cpu_free, cpu_gated};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // enable bit that governs each observed output
  function automatic int en_index(input int o);
    if (o < 10) return o;
    if (o < 26) return 10 + (o - 10) / 4;
    return o - 12;
  endfunction

  function automatic real half_ns(input int o);
    if (o < 3)  return 4.0;
    if (o < 10) return 12.0;
    if (o < 27) return 5.0;
    return 7.0;
  endfunction

  function automatic bit on_global_stop(input int o);
    return (o < 2) || (o >= 10 && o < 26) || (o == 27);
  endfunction

  function automatic bit on_pci_stop(input int o);
    return (o >= 3 && o < 9);
  endfunction

  realtime t_rise [N_OBS];
  int      rises  [N_OBS];
  int      base   [N_OBS];

  for (genvar i = 0; i < N_OBS; i++) begin : g_mon
    initial begin t_rise[i] = -1.0; rises[i] = 0; end
    always @(posedge obs[i]) begin
      rises[i]++;
      t_rise[i] = $realtime;
    end
    always @(negedge obs[i]) begin
      if (t_rise[i] >= 0.0) begin
        realtime w;
        w = $realtime - t_rise[i];
        // R8: high pulse equals half the source period
        chk((w > half_ns(i) - 0.01) && (w < half_ns(i) + 0.01), "R8",
            $sformatf("pulse width ps on output %0d", i),
            longint'(w * 1000.0), longint'(half_ns(i) * 1000.0));
      end
    end
  end

  task automatic activity(input bit gstop, input bit pstop, input string req);
    #100;
    for (int o = 0; o < N_OBS; o++) base[o] = rises[o];
    #200;
    for (int o = 0; o < N_OBS; o++) begin
      bit exp_act;
      bit act;
      exp_act = en_all[en_index(o)] && !(gstop && on_global_stop(o)) && !(pstop && on_pci_stop(o));
      act = (rises[o] - base[o]) > 0;
      chk(act == exp_act, req, $sformatf("activity of output %0d", o), act, exp_act);
    end
  endtask

  initial begin
    #200us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; stop_all_n = 1; pci_stop_n = 1; mode = 2'b00; en_all = '1;
    #50;
    chk(obs == '0, "R1", "outputs during reset", obs, 0);
    #50.3;
    rst_n = 1;
    activity(1'b0, 1'b0, "R1");

    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      #1;
      chk(out_en == (m != 3), "R9", $sformatf("out_en for mode %0d", m), out_en, (m != 3));
    end
    mode = 2'b00;

    // R2: global stop entered in the low phase of the processor clock
    @(negedge cpu_clk); #0.3; stop_all_n = 0;
    @(posedge cpu_clk); #1; chk(cpu_gated == 2'b11, "R2", "first edge after stop", cpu_gated, 3);
    @(posedge cpu_clk); #1; chk(cpu_gated == 2'b11, "R2", "second edge after stop", cpu_gated, 3);
    @(posedge cpu_clk); #1; chk(cpu_gated == 2'b00, "R2", "third edge after stop", cpu_gated, 0);
    activity(1'b1, 1'b0, "R2");

    // R3: restart
    @(negedge cpu_clk); #0.3; stop_all_n = 1;
    @(posedge cpu_clk); #1; chk(cpu_gated == 2'b00, "R3", "first edge after restart", cpu_gated, 0);
    @(posedge cpu_clk); #1; chk(cpu_gated == 2'b00, "R3", "second edge after restart", cpu_gated, 0);
    @(posedge cpu_clk); #1; chk(cpu_gated == 2'b11, "R3", "third edge after restart", cpu_gated, 3);
    activity(1'b0, 1'b0, "R3");

    // R5: PCI stop sampled on the PCI rising edge
    @(negedge pci_clk); #0.3; pci_stop_n = 0;
    @(posedge pci_clk); #1;
    chk(pci_gated == 6'h3F, "R5", "sampling edge passes", pci_gated, 63);
    chk(pci_free == 1'b1, "R4", "pci free at sampling edge", pci_free, 1);
    @(posedge pci_clk); #1;
    chk(pci_gated == 6'h00, "R5", "next edge parked", pci_gated, 0);
    chk(pci_free == 1'b1, "R4", "pci free while parked", pci_free, 1);
    activity(1'b0, 1'b1, "R6");
    @(negedge pci_clk); #0.3; pci_stop_n = 1;
    @(posedge pci_clk); #1; chk(pci_gated == 6'h00, "R5", "sampling edge still parked", pci_gated, 0);
    @(posedge pci_clk); #1; chk(pci_gated == 6'h3F, "R5", "next edge resumed", pci_gated, 63);
    activity(1'b0, 1'b0, "R5");

    // R4: both stops at once leave only the free-running outputs
    stop_all_n = 0; pci_stop_n = 0;
    activity(1'b1, 1'b1, "R4");
    stop_all_n = 1; pci_stop_n = 1;
    activity(1'b0, 1'b0, "R6");

    // R7: sweep every enable bit
    for (int b = 0; b < N_EN; b++) begin
      en_all = '1;
      en_all[b] = 1'b0;
      activity(1'b0, 1'b0, "R7");
    end
    en_all = '1;
    activity(1'b0, 1'b0, "R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule